// File: doc/BRIEF.md
# Lane Descrambler (self-synchronous, 1 + x^14 + x^15)

This block sits on one receive lane of a high-speed serial link, after word alignment and 8b/10b decoding. On each clock it can accept one 16-bit word, which carries two octets, and it returns the matching 16-bit word one cycle later. Once the lane's alignment sequence has ended, each received bit is combined by XOR with the bits that arrived 14 and 15 positions earlier in serial order. All sixteen output bits are produced in parallel.

The 15-bit history register always holds the most recent received (scrambled) line bits. It does this even while words pass through unchanged. Because of this the descrambler locks by itself: whatever the starting history, every word after the first valid word is correct. The starting history comes from a seed input. The seed is loaded during reset, and loaded again each time the alignment-done flag drops, which marks the start of a new alignment sequence. A separate enable turns descrambling off entirely.

Top module: `lane_descrambler`

## Requirements
- R1: `dout_valid` equals the value `rx_valid` had in the previous clock cycle, so the latency is one registered cycle.
- R2: Serial order within a word runs from bit 15 (oldest) down to bit 0 (newest). Form the 31-bit stream E = {history[14:0], rx_word[15:0]}, where a higher index means an older bit. For a valid word with `descr_on`=1 and `align_done`=1, output bit i is E[i] ^ E[i+14] ^ E[i+15].
- R3: A synchronous reset (`rst_n`=0) loads `seed_state` into the history. history[0] is the bit received just before rx_word[15].
- R4: After any history value, the second and all later consecutive valid descrambled words equal the transmitter's plain data.
- R5: When `descr_on`=0, a valid word is output unchanged.
- R6: When `align_done`=0, a valid word is output unchanged. The history still takes in the received bits.
- R7: In a cycle where `align_done` is 0 and was 1 in the previous cycle, the history is reloaded from `seed_state`. In that cycle the reload takes priority over taking in the word.
- R8: While `rx_valid`=0, `dout_word` holds its last value.
- R9: After reset, `dout_valid`=0 and `dout_word`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_word | input | 16 | Aligned, decoded lane word; bit 15 is oldest |
| rx_valid | input | 1 | rx_word carries data this cycle |
| align_done | input | 1 | High once the lane alignment sequence has ended |
| descr_on | input | 1 | Descrambling enable |
| seed_state | input | 15 | Starting history value |
| dout_word | output | 16 | Descrambled (or passed) word |
| dout_valid | output | 1 | dout_word updated this cycle |

## Verification
The hardest case to reach is the one where the seed actually decides the output. That happens only when the first descrambled word arrives with no received words between the seed load and that word. Any earlier word would overwrite the history. To reach it, the stimulus drops the alignment flag for one idle cycle, raises it again, and sends the next word immediately. It repeats this for every single-bit seed, so each history position is shown to reach the output. Lock-in is checked by descrambling data that a bench transmitter model scrambled from a different state.

// File: rtl/lane_descr_pkg.sv
package lane_descr_pkg;
  typedef enum logic {PATH_PASS = 1'b0, PATH_DESCR = 1'b1} path_mode_e;
endpackage

// File: rtl/lane_descr_hist.sv
module lane_descr_hist #(
  parameter int HW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          take,
  input  logic [HW-1:0] seed,
  input  logic [HW-1:0] next_hist,
  output logic [HW-1:0] hist
);
  always_ff @(posedge clk) begin
    if (!rst_n || load) hist <= seed;
    else if (take)      hist <= next_hist;
  end

  AST_RESET_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> hist == $past(seed)); // R3
  AST_SEED_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load && rst_n) |-> hist == $past(seed)); // R7
endmodule

// File: rtl/lane_descr_core.sv
module lane_descr_core #(
  parameter int W = 16,
  parameter int NEAR = 14,
  parameter int FAR = 15
) (
  input  logic [FAR-1:0] hist,
  input  logic [W-1:0]   word,
  output logic [W-1:0]   plain,
  output logic [FAR-1:0] next_hist
);
  localparam int EW = FAR + W;
  logic [EW-1:0] ext;
  assign ext = {hist, word};

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign plain[i] = ext[i] ^ ext[i+NEAR] ^ ext[i+FAR];
  end
  assign next_hist = ext[FAR-1:0];
endmodule

// File: rtl/lane_descr_out.sv
module lane_descr_out
  import lane_descr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid,
  input  path_mode_e mode,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] plain,
  output logic [W-1:0] dout,
  output logic       dout_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_valid <= 1'b0;
      dout       <= '0;
    end else begin
      dout_valid <= valid;
      if (valid) dout <= (mode == PATH_DESCR) ? plain : raw;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> dout_valid); // R1
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> !dout_valid); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(dout)); // R8
endmodule

// File: rtl/lane_descrambler.sv
module lane_descrambler
  import lane_descr_pkg::*;
#(
  parameter int W = 16,
  parameter int NEAR = 14,
  parameter int FAR = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   rx_word,
  input  logic           rx_valid,
  input  logic           align_done,
  input  logic           descr_on,
  input  logic [FAR-1:0] seed_state,
  output logic [W-1:0]   dout_word,
  output logic           dout_valid
);
  logic           align_q;
  logic           reload_evt;
  logic           descr_fire;
  logic           take_evt;
  logic [FAR-1:0] hist;
  logic [FAR-1:0] next_hist;
  logic [W-1:0]   plain;
  path_mode_e     mode;

  always_ff @(posedge clk) begin
    if (!rst_n) align_q <= 1'b0;
    else        align_q <= align_done;
  end

  assign reload_evt = align_q & ~align_done;
  assign descr_fire = rx_valid & descr_on & align_done;
  assign take_evt   = rx_valid & ~reload_evt;
  assign mode       = descr_fire ? PATH_DESCR : PATH_PASS;

  lane_descr_hist #(.HW(FAR)) u_hist (
    .clk(clk), .rst_n(rst_n), .load(reload_evt), .take(take_evt),
    .seed(seed_state), .next_hist(next_hist), .hist(hist)
  );

  lane_descr_core #(.W(W), .NEAR(NEAR), .FAR(FAR)) u_core (
    .hist(hist), .word(rx_word), .plain(plain), .next_hist(next_hist)
  );

  lane_descr_out #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .valid(rx_valid), .mode(mode),
    .raw(rx_word), .plain(plain), .dout(dout_word), .dout_valid(dout_valid)
  );

  // Checker state: the last two words seen at the ports, used to check lock-in.
  logic [W-1:0] chk_w1, chk_w2;
  logic         chk_ok1, chk_ok2, chk_f1;
  logic [FAR+W-1:0] chk_ext;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_w1 <= '0; chk_w2 <= '0;
      chk_ok1 <= 1'b0; chk_ok2 <= 1'b0; chk_f1 <= 1'b0;
    end else begin
      chk_w1  <= rx_word;
      chk_w2  <= chk_w1;
      chk_ok1 <= rx_valid & ~reload_evt;
      chk_ok2 <= chk_ok1;
      chk_f1  <= descr_fire;
    end
  end
  assign chk_ext = {chk_w2[FAR-1:0], chk_w1};

  for (genvar i = 0; i < W; i++) begin : g_lock
    AST_SELF_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_f1 && chk_ok1 && chk_ok2) |->
        dout_word[i] == (chk_ext[i] ^ chk_ext[i+NEAR] ^ chk_ext[i+FAR])); // R4
  end

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !(descr_on && align_done)) |=> dout_word == $past(rx_word)); // R5
endmodule

// File: tb/lane_descrambler_test.sv
module lane_descrambler_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] rx_word = '0;
  logic        rx_valid = 1'b0;
  logic        align_done = 1'b0;
  logic        descr_on = 1'b1;
  logic [14:0] seed_state = 15'h2B5D;
  logic [15:0] dout_word;
  logic        dout_valid;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  logic [14:0] m_last;
  logic        m_align_q;
  logic [15:0] m_out;

  always #5 clk = ~clk;

  lane_descrambler uut (
    .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .rx_valid(rx_valid),
    .align_done(align_done), .descr_on(descr_on), .seed_state(seed_state),
    .dout_word(dout_word), .dout_valid(dout_valid)
  );

  // Serial model: l[k] is the bit received k+1 positions ago.
  function automatic logic [15:0] m_descr(input logic [15:0] w, input logic [14:0] l);
    logic [15:0] r;
    for (int i = 15; i >= 0; i--) begin
      r[i] = w[i] ^ l[13] ^ l[14];
      l = {l[13:0], w[i]};
    end
    return r;
  endfunction

  function automatic logic [14:0] m_adv(input logic [15:0] w, input logic [14:0] l);
    for (int i = 15; i >= 0; i--) l = {l[13:0], w[i]};
    return l;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; drives, clocks, then checks 2 ns after the rising edge.
  task automatic step(input logic [15:0] w, input logic v, input logic en,
                      input logic al, input string req);
    logic [15:0] exp_w;
    logic reload;
    rx_word = w; rx_valid = v; descr_on = en; align_done = al;
    reload = m_align_q && !al;
    exp_w = m_out;
    if (v) exp_w = (en && al) ? m_descr(w, m_last) : w;
    if (reload)  m_last = seed_state;
    else if (v)  m_last = m_adv(w, m_last);
    m_align_q = al;
    m_out = exp_w;
    @(posedge clk); #2;
    check(req, {31'd0, dout_valid}, {31'd0, v});
    check(req, {16'd0, dout_word}, {16'd0, exp_w});
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    logic [14:0] tx;
    logic [15:0] plain, scr, s_bit;
    // R9 / R3: reset loads seed; alignment already done so first word uses seed
    align_done = 1'b1;
    repeat (3) @(negedge clk);
    #0 ;
    @(posedge clk); #2;
    check("R9", {31'd0, dout_valid}, 32'd0);
    check("R9", {16'd0, dout_word}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    m_last = seed_state; m_align_q = 1'b0; m_out = '0;
    // align_q is 0 out of reset, so no reload on first step
    step(16'h0000, 1'b1, 1'b1, 1'b1, "R3");
    step(16'hFFFF, 1'b1, 1'b1, 1'b1, "R2");

    // R6: new alignment sequence, words pass unchanged, history tracks
    lf = 16'hACE1;
    for (int k = 0; k < 8; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf, 1'b1, 1'b1, 1'b0, "R6");
    end
    // R2 / R8: descrambling with idle gaps
    for (int k = 0; k < 300; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf, (k % 5) != 3, 1'b1, 1'b1, ((k % 5) == 3) ? "R8" : "R2");
    end
    // R5: enable off
    for (int k = 0; k < 20; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf, 1'b1, 1'b0, 1'b1, "R5");
    end
    // R7 / R3: every single-bit seed reaches the output through a reload
    for (int k = 0; k < 15; k++) begin
      seed_state = 15'(1) << k;
      step(16'h1234, 1'b0, 1'b1, 1'b0, "R7");
      step(16'h0000, 1'b1, 1'b1, 1'b1, "R7");
      step(16'h5A5A, 1'b1, 1'b1, 1'b1, "R2");
    end
    // R7: reload wins over a word arriving in the same cycle
    seed_state = 15'h4C21;
    step(16'hBEEF, 1'b1, 1'b1, 1'b0, "R7");
    step(16'h0F0F, 1'b1, 1'b1, 1'b1, "R7");

    // R4: transmitter scrambles from a state unrelated to the seed
    seed_state = 15'h1357;
    step(16'h0, 1'b0, 1'b1, 1'b0, "R7");
    tx = 15'h6A0C;
    for (int k = 0; k < 40; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      plain = lf;
      for (int i = 15; i >= 0; i--) begin
        s_bit[i] = plain[i] ^ tx[13] ^ tx[14];
        tx = {tx[13:0], s_bit[i]};
      end
      scr = s_bit;
      step(scr, 1'b1, 1'b1, 1'b1, "R2");
      if (k > 0) check("R4", {16'd0, dout_word}, {16'd0, plain});
    end
    // R1: valid low yields valid low next cycle
    step(16'h0, 1'b0, 1'b1, 1'b1, "R1");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule